// File: doc/BRIEF.md
# Multi-Mode Power-Down Sequencer

This block decides which clocks of a small microcontroller keep toggling. Besides normal run it offers five low-power modes, and each one stops a different group of clocks. It drives four enables: the processor core clock, the clock of the on-chip peripherals, the oscillator, and the clock-output pin. Software picks a mode code and issues an entry strobe. The block then removes the matching enables and waits for one of the wake events that the chosen mode accepts.

Once a wake event arrives, the block does not return to run straight away. It holds the stopped clocks off for a recovery interval whose length depends on the mode. This interval gives the oscillator time to settle. The interval is counted in half-clock units, so that a fractional one-and-a-half-clock term is exact. For the deepest mode a quick-restart option shortens the wait. The peripheral-only stop mode is left only by a software exit strobe, and it has no recovery interval. A synchronous reset returns the block to run at once from any state.

Top module: `pwrdn_seq`

## Requirements
- R1: After reset all four enables (`cpu_clk_en`, `io_clk_en`, `osc_en`, `clkout_en`) are 1, `run_ready` is 1 and `mode_q` is 0.
- R2: When the block is in run, `enter_stb` with `mode_sel` in 1..5 loads that code into `mode_q` and sets the enables {cpu,io,osc,clkout} at the same clock edge. The codes and their enables are: 1 = light sleep, 0111; 2 = peripheral stop, 1011; 3 = system stop, 0011; 4 = idle, 0010; 5 = deep standby, 0000. `run_ready` goes to 0 at that edge.
- R3: When the block is in run, `enter_stb` with `mode_sel` equal to 0, 6 or 7 is ignored. The block stays in run with all enables at 1.
- R4: Peripheral stop (code 2) ignores `irq` and `busreq`. A `sw_exit` strobe returns it to run at the next edge, with no recovery interval.
- R5: Light sleep (1) and system stop (3) wake only on `irq`. In every mode other than 2, `busreq` in modes 1 and 3 has no effect, and neither has `sw_exit`.
- R6: Idle (4) and deep standby (5) wake on either `irq` or `busreq`.
- R7: Recovery lasts H half-clocks and ends ceil(H/2) clock edges after the wake edge. H is 3 for modes 1 and 3, and 2^(IDLE_EXP+1)+3 for mode 4. For mode 5, H is 2^(STBY_NORM_EXP+1)+3, or 2^(STBY_QUICK_EXP+1)+3 if `quick_rcv` is 1 at the wake edge.
- R8: During recovery `osc_en` is 1 and `run_ready` is 0. The other three enables keep the values they had in the mode.
- R9: While the block is not in run, `enter_stb` has no effect. During recovery, `irq` and `busreq` do not change the recovery length. At the end of recovery all enables return to 1 and `mode_q` returns to 0.
- R10: A synchronous `rst` brings the block back to run at the next edge from any state, including recovery, and clears `mode_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Requested low-power mode code |
| enter_stb | input | 1 | Enter the requested mode (accepted only in run) |
| quick_rcv | input | 1 | Selects short deep-standby recovery |
| irq | input | 1 | Interrupt request wake event |
| busreq | input | 1 | Bus request wake event |
| sw_exit | input | 1 | Software exit from peripheral stop |
| cpu_clk_en | output | 1 | Core clock enable |
| io_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| clkout_en | output | 1 | Clock-output pin enable |
| run_ready | output | 1 | High while in run |
| mode_q | output | 3 | Current mode code, 0 in run |

## Verification
Some properties are checked by assertions on every cycle. These are: the oscillator stays on and run_ready stays low throughout recovery; deep standby stops all four clocks; illegal codes and entry strobes outside run leave the state unchanged; peripheral stop never produces a wake event; the half-clock counter steps down by two each cycle. Other behaviour can only be shown by the bench scenarios. This covers the exact number of recovery cycles per mode and per quick option, the fact that noisy wake inputs during recovery leave that length unchanged, the per-mode wake filtering, and a reset that lands in the middle of recovery.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  typedef enum logic [2:0] {
    MD_RUN     = 3'd0,
    MD_SLEEP   = 3'd1,
    MD_IOSTOP  = 3'd2,
    MD_SYSSTOP = 3'd3,
    MD_IDLE    = 3'd4,
    MD_STANDBY = 3'd5
  } pd_mode_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_LOWP  = 2'd1,
    ST_RECOV = 2'd2
  } pd_state_e;

  typedef struct packed {
    logic cpu;
    logic io;
    logic osc;
    logic co;
  } clk_en_t;

  function automatic logic mode_legal(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd5);
  endfunction

  function automatic clk_en_t mode_gate(input pd_mode_e m);
    clk_en_t g;
    case (m)
      MD_SLEEP:   g = '{cpu: 1'b0, io: 1'b1, osc: 1'b1, co: 1'b1};
      MD_IOSTOP:  g = '{cpu: 1'b1, io: 1'b0, osc: 1'b1, co: 1'b1};
      MD_SYSSTOP: g = '{cpu: 1'b0, io: 1'b0, osc: 1'b1, co: 1'b1};
      MD_IDLE:    g = '{cpu: 1'b0, io: 1'b0, osc: 1'b1, co: 1'b0};
      MD_STANDBY: g = '{cpu: 1'b0, io: 1'b0, osc: 1'b0, co: 1'b0};
      default:    g = '{cpu: 1'b1, io: 1'b1, osc: 1'b1, co: 1'b1};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/pwrdn_wake_dec.sv
module pwrdn_wake_dec
  import pwrdn_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pd_mode_e mode,
  input  logic     irq,
  input  logic     busreq,
  input  logic     sw_exit,
  output logic     wake_ev,
  output logic     sw_ret
);

  always_comb begin
    wake_ev = 1'b0;
    sw_ret  = 1'b0;
    case (mode)
      MD_SLEEP, MD_SYSSTOP: wake_ev = irq;
      MD_IDLE, MD_STANDBY:  wake_ev = irq | busreq;
      MD_IOSTOP:            sw_ret  = sw_exit;
      default: begin
        wake_ev = 1'b0;
        sw_ret  = 1'b0;
      end
    endcase
  end

  AST_IOSTOP_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_IOSTOP) |-> !wake_ev); // R4

  AST_LIGHT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    ((mode == MD_SLEEP || mode == MD_SYSSTOP) && !irq) |-> (!wake_ev && !sw_ret)); // R5

endmodule

// File: rtl/pwrdn_rcv_cnt.sv
module pwrdn_rcv_cnt
  import pwrdn_pkg::*;
#(
  parameter int IDLE_EXP       = 8,
  parameter int STBY_NORM_EXP  = 17,
  parameter int STBY_QUICK_EXP = 6
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  pd_mode_e mode,
  input  logic     quick,
  input  logic     active,
  output logic     done
);

  localparam int MAX_A = (IDLE_EXP > STBY_NORM_EXP) ? IDLE_EXP : STBY_NORM_EXP;
  localparam int MAX_E = (MAX_A > STBY_QUICK_EXP) ? MAX_A : STBY_QUICK_EXP;
  localparam int CNT_W = MAX_E + 3;

  localparam logic [CNT_W-1:0] HC_SHORT = CNT_W'(3);
  localparam logic [CNT_W-1:0] HC_IDLE  = (CNT_W'(1) << (IDLE_EXP + 1)) + CNT_W'(3);
  localparam logic [CNT_W-1:0] HC_NORM  = (CNT_W'(1) << (STBY_NORM_EXP + 1)) + CNT_W'(3);
  localparam logic [CNT_W-1:0] HC_QUICK = (CNT_W'(1) << (STBY_QUICK_EXP + 1)) + CNT_W'(3);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ld_val;

  always_comb begin
    case (mode)
      MD_IDLE:    ld_val = HC_IDLE;
      MD_STANDBY: ld_val = quick ? HC_QUICK : HC_NORM;
      default:    ld_val = HC_SHORT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= ld_val;
    end else if (active && (cnt > CNT_W'(2))) begin
      cnt <= cnt - CNT_W'(2);
    end
  end

  assign done = active && (cnt <= CNT_W'(2));

  AST_HALF_STEP: assert property (@(posedge clk) disable iff (rst)
    (active && !load && (cnt > CNT_W'(2))) |=> (cnt == $past(cnt) - CNT_W'(2))); // R7

endmodule

// File: rtl/pwrdn_clk_gate.sv
module pwrdn_clk_gate
  import pwrdn_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pd_state_e nxt_state,
  input  pd_mode_e  nxt_mode,
  output logic      cpu_clk_en,
  output logic      io_clk_en,
  output logic      osc_en,
  output logic      clkout_en,
  output logic      run_ready
);

  clk_en_t g_nxt;

  always_comb begin
    case (nxt_state)
      ST_LOWP:  g_nxt = mode_gate(nxt_mode);
      ST_RECOV: begin
        g_nxt     = mode_gate(nxt_mode);
        g_nxt.osc = 1'b1;
      end
      default:  g_nxt = '{cpu: 1'b1, io: 1'b1, osc: 1'b1, co: 1'b1};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en <= 1'b1;
      io_clk_en  <= 1'b1;
      osc_en     <= 1'b1;
      clkout_en  <= 1'b1;
      run_ready  <= 1'b1;
    end else begin
      cpu_clk_en <= g_nxt.cpu;
      io_clk_en  <= g_nxt.io;
      osc_en     <= g_nxt.osc;
      clkout_en  <= g_nxt.co;
      run_ready  <= (nxt_state == ST_RUN);
    end
  end

  AST_RECOV_OSC_ON: assert property (@(posedge clk) disable iff (rst)
    (nxt_state == ST_RECOV) |=> (osc_en && !run_ready)); // R8

  AST_STBY_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (nxt_state == ST_LOWP && nxt_mode == MD_STANDBY)
      |=> !(cpu_clk_en || io_clk_en || osc_en || clkout_en)); // R2

endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pwrdn_pkg::*;
#(
  parameter int IDLE_EXP       = 8,
  parameter int STBY_NORM_EXP  = 17,
  parameter int STBY_QUICK_EXP = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode_sel,
  input  logic       enter_stb,
  input  logic       quick_rcv,
  input  logic       irq,
  input  logic       busreq,
  input  logic       sw_exit,
  output logic       cpu_clk_en,
  output logic       io_clk_en,
  output logic       osc_en,
  output logic       clkout_en,
  output logic       run_ready,
  output logic [2:0] mode_q
);

  pd_state_e state, nxt_state;
  pd_mode_e  mode_r, nxt_mode;
  logic      wake_ev, sw_ret, rcv_load, rcv_done;

  pwrdn_wake_dec u_wake (
    .clk     (clk),
    .rst     (rst),
    .mode    ((state == ST_LOWP) ? mode_r : MD_RUN),
    .irq     (irq),
    .busreq  (busreq),
    .sw_exit (sw_exit),
    .wake_ev (wake_ev),
    .sw_ret  (sw_ret)
  );

  pwrdn_rcv_cnt #(
    .IDLE_EXP       (IDLE_EXP),
    .STBY_NORM_EXP  (STBY_NORM_EXP),
    .STBY_QUICK_EXP (STBY_QUICK_EXP)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load   (rcv_load),
    .mode   (mode_r),
    .quick  (quick_rcv),
    .active (state == ST_RECOV),
    .done   (rcv_done)
  );

  always_comb begin
    nxt_state = state;
    nxt_mode  = mode_r;
    rcv_load  = 1'b0;
    case (state)
      ST_RUN: begin
        if (enter_stb && mode_legal(mode_sel)) begin
          nxt_state = ST_LOWP;
          nxt_mode  = pd_mode_e'(mode_sel);
        end
      end
      ST_LOWP: begin
        if (sw_ret) begin
          nxt_state = ST_RUN;
          nxt_mode  = MD_RUN;
        end else if (wake_ev) begin
          nxt_state = ST_RECOV;
          rcv_load  = 1'b1;
        end
      end
      ST_RECOV: begin
        if (rcv_done) begin
          nxt_state = ST_RUN;
          nxt_mode  = MD_RUN;
        end
      end
      default: begin
        nxt_state = ST_RUN;
        nxt_mode  = MD_RUN;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_RUN;
      mode_r <= MD_RUN;
    end else begin
      state  <= nxt_state;
      mode_r <= nxt_mode;
    end
  end

  pwrdn_clk_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .nxt_state  (rst ? ST_RUN : nxt_state),
    .nxt_mode   (nxt_mode),
    .cpu_clk_en (cpu_clk_en),
    .io_clk_en  (io_clk_en),
    .osc_en     (osc_en),
    .clkout_en  (clkout_en),
    .run_ready  (run_ready)
  );

  assign mode_q = mode_r;

  AST_RST_TO_RUN: assert property (@(posedge clk)
    rst |=> (run_ready && mode_q == 3'd0 && cpu_clk_en && osc_en)); // R10

  AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && enter_stb && !mode_legal(mode_sel)) |=> (state == ST_RUN)); // R3

  AST_NO_ENTRY_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN) |=> ((state == ST_RUN) || (mode_r == $past(mode_r)))); // R9

endmodule

// File: tb/tb_pwrdn_seq.sv
`timescale 1ns/1ps
module tb_pwrdn_seq;

  localparam int IDLE_E  = 8;
  localparam int NORM_E  = 10;
  localparam int QUICK_E = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode_sel = 3'd0;
  logic       enter_stb = 1'b0, quick_rcv = 1'b0, irq = 1'b0, busreq = 1'b0, sw_exit = 1'b0;
  logic       cpu_clk_en, io_clk_en, osc_en, clkout_en, run_ready;
  logic [2:0] mode_q;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwrdn_seq #(.IDLE_EXP(IDLE_E), .STBY_NORM_EXP(NORM_E), .STBY_QUICK_EXP(QUICK_E)) dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .enter_stb(enter_stb), .quick_rcv(quick_rcv),
    .irq(irq), .busreq(busreq), .sw_exit(sw_exit), .cpu_clk_en(cpu_clk_en),
    .io_clk_en(io_clk_en), .osc_en(osc_en), .clkout_en(clkout_en),
    .run_ready(run_ready), .mode_q(mode_q)
  );

  function automatic logic [3:0] exp_gate(input int m);
    case (m)
      1: return 4'b0111;
      2: return 4'b1011;
      3: return 4'b0011;
      4: return 4'b0010;
      5: return 4'b0000;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic int exp_cycles(input int m, input bit q);
    int hc;
    if (m == 4) hc = (1 << (IDLE_E + 1)) + 3;
    else if (m == 5) hc = q ? (1 << (QUICK_E + 1)) + 3 : (1 << (NORM_E + 1)) + 3;
    else hc = 3;
    return (hc + 1) / 2;
  endfunction

  function automatic bit exp_wake(input int m, input bit i, input bit b);
    if (m == 1 || m == 3) return i;
    if (m == 4 || m == 5) return i | b;
    return 1'b0;
  endfunction

  function automatic logic [3:0] gates();
    return {cpu_clk_en, io_clk_en, osc_en, clkout_en};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_run(input string req);
    chk(gates() == 4'b1111 && run_ready && mode_q == 3'd0, req,
        {gates(), run_ready, mode_q}, {4'b1111, 1'b1, 3'd0});
  endtask

  task automatic enter(input int m);
    mode_sel = m[2:0];
    enter_stb = 1'b1;
    step();
    enter_stb = 1'b0;
  endtask

  task automatic check_mode(input int m, input string req);
    chk(gates() == exp_gate(m) && !run_ready && mode_q == m[2:0], req,
        {gates(), run_ready, mode_q}, {exp_gate(m), 1'b0, m[2:0]});
  endtask

  // called one cycle after the wake edge; measures remaining recovery
  task automatic measure(input int m, input bit q, input bit noisy);
    int n;
    logic [3:0] g;
    g = exp_gate(m) | 4'b0010;
    chk(gates() == g && !run_ready, "R8 recovery gating", {gates(), run_ready}, {g, 1'b0});
    n = 0;
    while (!run_ready && n < 150000) begin
      if (noisy) begin
        irq = 1'($urandom % 2);
        busreq = 1'($urandom % 2);
        enter_stb = 1'($urandom % 2);
        mode_sel = 3'd5;
      end
      step();
      n++;
    end
    irq = 1'b0; busreq = 1'b0; enter_stb = 1'b0;
    chk(n == exp_cycles(m, q), noisy ? "R9 length with noise" : "R7 recovery length",
        n, exp_cycles(m, q));
    check_run("R9 back to run");
  endtask

  task automatic wake_irq(input int m, input bit q);
    quick_rcv = q;
    irq = 1'b1;
    step();
    irq = 1'b0;
    measure(m, q, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-reqs act=190000 exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    step(); step();
    rst = 1'b0;
    step();
    check_run("R1 reset state");

    // R3 illegal codes
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c == 6 || c == 7) begin
        enter(c);
        check_run("R3 illegal code ignored");
      end
    end

    // R2/R5 light sleep and system stop
    for (int k = 0; k < 2; k++) begin
      int m;
      m = (k == 0) ? 1 : 3;
      enter(m);
      check_mode(m, "R2 entry gating");
      busreq = 1'b1; sw_exit = 1'b1;
      step();
      busreq = 1'b0; sw_exit = 1'b0;
      check_mode(m, "R5 busreq/sw_exit ignored");
      wake_irq(m, 1'b0);
    end

    // R4 peripheral stop
    enter(2);
    check_mode(2, "R2 entry gating");
    irq = 1'b1; busreq = 1'b1;
    step(); step();
    irq = 1'b0; busreq = 1'b0;
    check_mode(2, "R4 events ignored");
    enter(4);
    check_mode(2, "R9 entry outside run ignored");
    sw_exit = 1'b1;
    step();
    sw_exit = 1'b0;
    check_run("R4 sw exit immediate");

    // R6 idle via busreq
    enter(4);
    check_mode(4, "R2 entry gating");
    sw_exit = 1'b1;
    step();
    sw_exit = 1'b0;
    check_mode(4, "R5 sw_exit ignored in idle");
    busreq = 1'b1;
    step();
    busreq = 1'b0;
    chk(!run_ready, "R6 busreq wakes idle", run_ready, 0);
    measure(4, 1'b0, 1'b0);

    // R7 standby normal and quick, R6 via busreq
    enter(5);
    check_mode(5, "R2 entry gating");
    wake_irq(5, 1'b0);
    enter(5);
    quick_rcv = 1'b1;
    busreq = 1'b1;
    step();
    busreq = 1'b0;
    measure(5, 1'b1, 1'b0);

    // R9 noisy recovery
    enter(4);
    irq = 1'b1;
    step();
    irq = 1'b0;
    measure(4, 1'b0, 1'b1);

    // R10 reset in low power and in recovery
    enter(5);
    rst = 1'b1; step(); rst = 1'b0;
    check_run("R10 reset from standby");
    enter(4);
    irq = 1'b1; step(); irq = 1'b0;
    step(); step();
    rst = 1'b1; step(); rst = 1'b0;
    check_run("R10 reset during recovery");
    step();
    check_run("R10 stays in run");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int m;
      bit i, b, s, q;
      m = int'($urandom % 8);
      enter(m);
      if (m == 0 || m > 5) begin
        check_run("R3 random illegal code");
        continue;
      end
      check_mode(m, "R2 random entry");
      i = 1'($urandom % 2); b = 1'($urandom % 2); s = 1'($urandom % 2); q = 1'($urandom % 2);
      quick_rcv = q; irq = i; busreq = b; sw_exit = s;
      step();
      irq = 1'b0; busreq = 1'b0; sw_exit = 1'b0;
      if (m == 2) begin
        if (s) check_run("R4 random sw exit");
        else begin
          check_mode(2, "R4 random hold");
          sw_exit = 1'b1; step(); sw_exit = 1'b0;
          check_run("R4 random sw exit");
        end
      end else if (exp_wake(m, i, b)) begin
        measure(m, q, 1'($urandom % 2));
      end else begin
        check_mode(m, "R5 random no wake");
        wake_irq(m, q);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule